// File: doc/BRIEF.md
# Memory Bus Agent with Acknowledge

This block is a bus slave that sits on an 8-bit address bus with a single master. It owns the whole address space. The lowest part of the space, addresses 0x00 through 0x1f, is a read-only table whose contents are computed at elaboration. The rest, 0x20 through 0xff, is read/write storage. Both the address and the two strobes are decoded in full, so there are no alias locations. An illegal strobe combination is refused.

The master raises exactly one of the read or write strobes and holds the address, and the write data if it is writing. The agent answers by driving an acknowledge line high on the next clock edge. On a read, it also drives the read data from that edge. When the strobe is dropped, the agent releases both the acknowledge and the read data to high impedance at the next edge. This lets other slaves share those wires.

Top module: `mem_bus_agent`

## Requirements
- R1: A read at any address from 0x00 to 0x1f returns the table value (addr*37 + 11) mod 256 (default parameters ROM_MULT=37, ROM_ADD=11).
- R2: A write at any address from 0x20 to 0xff stores the write data, and a later read of that address returns it.
- R3: A write at any address from 0x00 to 0x1f is acknowledged and leaves the table contents unchanged.
- R4: A cycle with both strobes high is not acknowledged and changes no storage location.
- R5: The acknowledge is driven high starting at the first rising clock edge where exactly one strobe is sampled high. It is released to high impedance at the first rising edge where no strobe is high.
- R6: The read data is driven only while a read is being acknowledged. At all other times it is high impedance, including during an acknowledged write.
- R7: After reset, with no strobe high, the acknowledge and the read data are both high impedance.
- R8: The decode has no holes and no aliases. Every one of the 256 addresses answers a single strobe, and the 224 read/write locations hold independent values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Bus address from the master |
| wdata | input | 8 | Write data from the master |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| rdata | output | 8 | Read data, high impedance unless a read is acknowledged |
| ack | output | 1 | Acknowledge, high impedance unless a single strobe is being answered |

## Verification
The following rules are checked by assertions on every cycle:
- A single strobe is always followed by a high acknowledge one edge later.
- The acknowledge is gone one edge after the strobes are removed.
- A double strobe never gets an acknowledge.
- The storage write enable never fires for a table address or for a double strobe.

Some behaviours can only be shown by the bench's scenarios. These are the actual table values, the stored data coming back from every read/write address, the absence of aliasing across the full sweep, and the read data being released during writes and idle cycles. The bench shows them by pulling the shared wires to known levels when they are released.

// File: rtl/mba_pkg.sv
package mba_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'b00,
      CYC_READ  = 2'b01,
      CYC_WRITE = 2'b10,
      CYC_BAD   = 2'b11
   } cyc_kind_e;
endpackage

// File: rtl/mba_decode.sv
module mba_decode
   import mba_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int ROM_LAST = 31
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_stb,
   input  logic              wr_stb,
   output logic              rom_hit,
   output logic              rd_ok,
   output logic              wr_ok,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_idx
);
   localparam int RAM_BASE = ROM_LAST + 1;

   cyc_kind_e kind;

   always_comb begin
      kind    = cyc_kind_e'({wr_stb, rd_stb});
      rom_hit = (int'(addr) <= ROM_LAST);
      rd_ok   = (kind == CYC_READ);
      wr_ok   = (kind == CYC_WRITE);
      ram_we  = wr_ok && !rom_hit;
      ram_idx = addr - ADDR_W'(RAM_BASE);
   end
endmodule

// File: rtl/mba_rom.sv
module mba_rom #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter int ROM_LAST = 31,
   parameter int ROM_MULT = 37,
   parameter int ROM_ADD  = 11
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);
   localparam int DEPTH = ROM_LAST + 1;

   logic [DATA_W-1:0] tbl [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      assign tbl[g] = DATA_W'(g * ROM_MULT + ROM_ADD);
   end

   always_comb begin
      data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (int'(addr) == i) data = tbl[i];
      end
   end
endmodule

// File: rtl/mba_ram.sv
module mba_ram #(
   parameter int IDX_W  = 8,
   parameter int DATA_W = 8,
   parameter int DEPTH  = 224
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we && int'(idx) < DEPTH) mem[idx] <= wdata;
   end

   always_comb begin
      rdata = '0;
      if (int'(idx) < DEPTH) rdata = mem[idx];
   end
endmodule

// File: rtl/mem_bus_agent.sv
module mem_bus_agent #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter int ROM_LAST = 31,
   parameter int ROM_MULT = 37,
   parameter int ROM_ADD  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_stb,
   input  logic              wr_stb,
   output tri   [DATA_W-1:0] rdata,
   output tri                ack
);
   localparam int SPACE     = 1 << ADDR_W;
   localparam int RAM_DEPTH = SPACE - (ROM_LAST + 1);

   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
      $error("mem_bus_agent: ADDR_W out of supported range");
   end
   if (ROM_LAST < 0 || ROM_LAST >= SPACE - 1) begin : g_bad_split
      $error("mem_bus_agent: ROM_LAST leaves no read/write region");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("mem_bus_agent: DATA_W must be positive");
   end

   logic              rom_hit, rd_ok, wr_ok, ram_we;
   logic [ADDR_W-1:0] ram_idx;
   logic [DATA_W-1:0] rom_q, ram_q, rd_val;
   logic              ack_q, rd_q;
   logic [DATA_W-1:0] rdata_q;

   mba_decode #(.ADDR_W(ADDR_W), .ROM_LAST(ROM_LAST)) u_dec (
      .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
      .rom_hit(rom_hit), .rd_ok(rd_ok), .wr_ok(wr_ok),
      .ram_we(ram_we), .ram_idx(ram_idx)
   );

   mba_rom #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_LAST(ROM_LAST),
      .ROM_MULT(ROM_MULT), .ROM_ADD(ROM_ADD)
   ) u_rom (
      .addr(addr), .data(rom_q)
   );

   mba_ram #(.IDX_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(RAM_DEPTH)) u_ram (
      .clk(clk), .we(ram_we), .idx(ram_idx), .wdata(wdata), .rdata(ram_q)
   );

   assign rd_val = rom_hit ? rom_q : ram_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         rd_q    <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q <= rd_ok || wr_ok;
         rd_q  <= rd_ok;
         if (rd_ok) rdata_q <= rd_val;
      end
   end

   assign ack   = ack_q ? 1'b1 : 1'bz;
   assign rdata = (ack_q && rd_q) ? rdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/mba_checker.sv
module mba_checker #(
   parameter int ADDR_W   = 8,
   parameter int ROM_LAST = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              rd_stb,
   input logic              wr_stb,
   input logic              ack,
   input logic              ram_we
);
   a_r5_ack_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb ^ wr_stb) |=> (ack == 1'b1));

   a_r5_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stb && !wr_stb) |=> (ack != 1'b1));

   a_r4_no_ack_double: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && wr_stb) |=> (ack != 1'b1));

   a_r4_no_store_double: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && wr_stb) |-> !ram_we);

   a_r3_rom_never_written: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (int'(addr) > ROM_LAST));
endmodule

bind mem_bus_agent mba_checker #(.ADDR_W(ADDR_W), .ROM_LAST(ROM_LAST)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb),
   .wr_stb(wr_stb), .ack(ack), .ram_we(ram_we)
);

// File: tb/tb_mem_bus_agent.sv
module tb_mem_bus_agent;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       rd_stb = 1'b0;
   logic       wr_stb = 1'b0;
   wire  [7:0] rdata_w;
   wire        ack_w;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pulldown pd_ack (ack_w);
   for (genvar b = 0; b < 8; b++) begin : g_pu
      pullup pu_d (rdata_w[b]);
   end

   mem_bus_agent dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .rdata(rdata_w), .ack(ack_w)
   );

   function automatic logic [7:0] rom_exp(input int a);
      return 8'((a * 37 + 11) % 256);
   endfunction

   function automatic logic [7:0] ram_pat(input int a, input int k);
      return 8'((a * 5 + k) % 256);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one transaction: strobes set after a falling edge, answer sampled one edge later
   task automatic cycle(input logic [7:0] a, input logic [7:0] d,
                        input bit r, input bit w, output bit got_ack,
                        output logic [7:0] got_d);
      @(negedge clk);
      addr = a; wdata = d; rd_stb = r; wr_stb = w;
      @(negedge clk);
      got_ack = ack_w;
      got_d   = rdata_w;
      rd_stb = 1'b0; wr_stb = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      bit         ak;
      logic [7:0] dv;
      repeat (3) @(negedge clk);
      // R7: reset state, released lines read as the pull levels
      check(ack_w == 1'b0, "R7 ack", ack_w, 0);
      check(rdata_w == 8'hff, "R7 rdata", rdata_w, 8'hff);
      rst_n = 1'b1;
      @(negedge clk);
      check(ack_w == 1'b0 && rdata_w == 8'hff, "R7 idle after reset", ack_w, 0);

      // R5: nothing before the first edge, ack after it, release after strobe drop
      addr = 8'h05; rd_stb = 1'b1;
      #1;
      check(ack_w == 1'b0, "R5 no ack before edge", ack_w, 0);
      @(negedge clk);
      check(ack_w == 1'b1, "R5 ack after edge", ack_w, 1);
      check(rdata_w == rom_exp(5), "R1 read 05", rdata_w, rom_exp(5));
      @(negedge clk);
      check(ack_w == 1'b1, "R5 ack held with strobe", ack_w, 1);
      rd_stb = 1'b0;
      #1;
      check(ack_w == 1'b1, "R5 ack still held before edge", ack_w, 1);
      @(negedge clk);
      check(ack_w == 1'b0, "R5 ack released", ack_w, 0);
      check(rdata_w == 8'hff, "R6 rdata released", rdata_w, 8'hff);

      // R1: full table sweep
      for (int a = 0; a < 32; a++) begin
         cycle(8'(a), 8'h00, 1'b1, 1'b0, ak, dv);
         check(ak == 1'b1, "R1 ack", ak, 1);
         check(dv == rom_exp(a), "R1 table", dv, rom_exp(a));
      end

      // R2/R8: write every read/write address with a distinct value
      for (int a = 32; a < 256; a++) begin
         cycle(8'(a), ram_pat(a, 3), 1'b0, 1'b1, ak, dv);
         check(ak == 1'b1, "R8 write ack", ak, 1);
         check(dv == 8'hff, "R6 rdata idle on write", dv, 8'hff);
      end
      for (int a = 32; a < 256; a++) begin
         cycle(8'(a), 8'h00, 1'b1, 1'b0, ak, dv);
         check(ak == 1'b1, "R8 read ack", ak, 1);
         check(dv == ram_pat(a, 3), "R2 readback", dv, ram_pat(a, 3));
      end

      // R3: writes to the table are acknowledged but ignored
      for (int a = 0; a < 32; a++) begin
         cycle(8'(a), ~rom_exp(a), 1'b0, 1'b1, ak, dv);
         check(ak == 1'b1, "R3 ack on table write", ak, 1);
      end
      for (int a = 0; a < 32; a++) begin
         cycle(8'(a), 8'h00, 1'b1, 1'b0, ak, dv);
         check(dv == rom_exp(a), "R3 table unchanged", dv, rom_exp(a));
      end

      // R4: double strobe, no ack, no storage change
      for (int a = 0; a < 256; a += 17) begin
         cycle(8'(a), 8'h5a, 1'b1, 1'b1, ak, dv);
         check(ak == 1'b0, "R4 no ack", ak, 0);
         check(dv == 8'hff, "R4 rdata released", dv, 8'hff);
      end
      for (int a = 0; a < 256; a += 17) begin
         cycle(8'(a), 8'h00, 1'b1, 1'b0, ak, dv);
         if (a < 32) check(dv == rom_exp(a), "R4 table kept", dv, rom_exp(a));
         else        check(dv == ram_pat(a, 3), "R4 storage kept", dv, ram_pat(a, 3));
      end

      // R2: second pattern over boundary addresses
      for (int a = 32; a < 256; a += 37) begin
         cycle(8'(a), ram_pat(a, 200), 1'b0, 1'b1, ak, dv);
         cycle(8'(a), 8'h00, 1'b1, 1'b0, ak, dv);
         check(dv == ram_pat(a, 200), "R2 rewrite", dv, ram_pat(a, 200));
      end
      cycle(8'hff, 8'hc3, 1'b0, 1'b1, ak, dv);
      cycle(8'hff, 8'h00, 1'b1, 1'b0, ak, dv);
      check(dv == 8'hc3, "R2 top address", dv, 8'hc3);
      cycle(8'h20, 8'h3c, 1'b0, 1'b1, ak, dv);
      cycle(8'h1f, 8'h00, 1'b1, 1'b0, ak, dv);
      check(dv == rom_exp(31), "R8 boundary table", dv, rom_exp(31));
      cycle(8'h20, 8'h00, 1'b1, 1'b0, ak, dv);
      check(dv == 8'h3c, "R8 boundary storage", dv, 8'h3c);

      done = 1'b1;
   end

   initial begin
      for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule